// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block shares one memory port among up to fourteen requesters. Each requester, called a client, is given a number. The block does not use a fixed rotation or a priority list. It walks a table of slots, and each slot names the client that owns it. Host configuration software fills the table. It gives a client several slots, spaced evenly, to set that client's share of the bandwidth. Slots that no client needs can be spread over the active clients in turn.

The block keeps two independent arbitration engines. One serves the external memory region and one serves the internal memory region. Each engine has its own slot table, its own slot pointer, its own request and done inputs, and its own grant outputs. A single write port loads one table entry per clock. The write selects a region, a slot index and a client number. The grant is one-hot and registered. It is held until the granted client reports that its transfer is complete, and only then does the slot pointer move on.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: The two regions are independent. A table write that selects one region (`cfg_region` 0 = external, 1 = internal) changes only that region's table. Activity in one region leaves the other region's pointer and grant unchanged.
- R2: While reset is asserted and directly after it, both regions show an all-zero grant, busy low and slot pointer 0. After reset every table entry reads as unowned, so the first grant in each region goes to the lowest-numbered requester.
- R3: In a cycle where a region is not busy and no client requests, no grant is issued. The pointer steps by exactly one on each such clock and wraps from the last slot (63) to 0.
- R4: When the region is not busy and the client named by the current slot (bit n of the grant vector is client n) is requesting, that client's grant bit is set on the next clock edge and busy rises.
- R5: When the owner of the current slot is not requesting but others are, the grant goes to the lowest-numbered requesting client.
- R6: A table entry whose value is 14 or greater (the entries are 4 bits wide) is unowned, and the lowest-numbered requester is granted.
- R7: While busy, the grant and the pointer stay unchanged until done is seen, even if every request is withdrawn.
- R8: A done pulse while busy clears the grant and busy on the next edge and advances the pointer by one. A done input while the region is idle has no effect on the pointer step.
- R9: A table write is used by decisions from the next clock onward. A write to the slot under a held grant does not alter that grant.
- R10: The grant vector has at most one bit set, and busy is high exactly when a grant bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Table write strobe |
| cfg_region | input | 1 | Region selected by the write: 0 external, 1 internal |
| cfg_slot | input | SLOT_W (6) | Slot index written |
| cfg_client | input | CID_W (4) | Client number stored in that slot |
| ext_req | input | N_CLIENTS (14) | External-region requests, bit n = client n |
| ext_done | input | 1 | Granted external transfer is complete |
| ext_gnt | output | N_CLIENTS (14) | External-region one-hot grant |
| ext_busy | output | 1 | External-region grant held |
| ext_slot | output | SLOT_W (6) | External-region slot pointer |
| int_req | input | N_CLIENTS (14) | Internal-region requests, bit n = client n |
| int_done | input | 1 | Granted internal transfer is complete |
| int_gnt | output | N_CLIENTS (14) | Internal-region one-hot grant |
| int_busy | output | 1 | Internal-region grant held |
| int_slot | output | SLOT_W (6) | Internal-region slot pointer |

## Verification
The bench builds the block with its defaults: 14 clients and 64 slots per region. With these values an idle walk of seventy cycles crosses the 63-to-0 wrap. The 4-bit entry field can also hold the out-of-range values 14 and 15, so the unowned rule can be driven through ordinary table writes. Client 13, the highest client number, exercises the top bit of the grant vector.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

  localparam int unsigned REGION_COUNT = 2;

  typedef enum logic [0:0] {
    RGN_EXT = 1'b0,
    RGN_INT = 1'b1
  } region_e;

endpackage

// File: rtl/tdm_slot_table.sv
// Per-region slot ownership storage: one write port, one combinational read port.
module tdm_slot_table #(
  parameter int N_SLOTS = 64,
  parameter int CID_W   = 4,
  parameter int SLOT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [CID_W-1:0]  wr_val,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [CID_W-1:0]  rd_val
);

  // All-ones is never a valid client number, so it marks an unowned slot.
  localparam logic [CID_W-1:0] UNOWNED = '1;

  logic [CID_W-1:0] mem_q [N_SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SLOTS; s++) begin
        mem_q[s] <= UNOWNED;
      end
    end else if (wr_en && (int'(wr_idx) < N_SLOTS)) begin
      mem_q[wr_idx] <= wr_val;
    end
  end

  always_comb begin
    rd_val = mem_q[rd_idx];
  end

  // R9: a write is stored and visible on the following clock
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/tdm_grant_picker.sv
// Chooses the winner for one slot: the slot owner if it requests,
// otherwise the lowest-numbered requester.
module tdm_grant_picker #(
  parameter int N_CLIENTS = 14,
  parameter int CID_W     = 4
) (
  input  logic [CID_W-1:0]     owner_id,
  input  logic [N_CLIENTS-1:0] req,
  output logic                 win_valid,
  output logic [N_CLIENTS-1:0] win_oh
);

  logic [N_CLIENTS-1:0] owner_oh;
  logic [N_CLIENTS-1:0] lowest_oh;
  logic                 owner_hit;

  // Decode the owner; values at or above N_CLIENTS decode to nothing.
  generate
    for (genvar c = 0; c < N_CLIENTS; c++) begin : g_owner_dec
      assign owner_oh[c] = (owner_id == CID_W'(c));
    end
  endgenerate

  always_comb begin
    lowest_oh = req & (~req + N_CLIENTS'(1));
    owner_hit = |(owner_oh & req);
    win_valid = |req;
    win_oh    = owner_hit ? owner_oh : lowest_oh;
  end

endmodule

// File: rtl/tdm_region_seq.sv
// Slot pointer, grant and busy state for one region.
module tdm_region_seq #(
  parameter int N_CLIENTS = 14,
  parameter int N_SLOTS   = 64,
  parameter int SLOT_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_valid,
  input  logic [N_CLIENTS-1:0] win_oh,
  input  logic                 xfer_done,
  output logic [SLOT_W-1:0]    slot_ptr,
  output logic [N_CLIENTS-1:0] gnt,
  output logic                 busy
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

  logic [SLOT_W-1:0]    ptr_q, ptr_nxt;
  logic [N_CLIENTS-1:0] gnt_q, gnt_nxt;
  logic                 busy_q, busy_nxt;
  logic                 advance, load, state_en;

  // Next-state
  always_comb begin
    advance = 1'b0;
    load    = 1'b0;
    if (busy_q) begin
      advance = xfer_done;
    end else if (win_valid) begin
      load = 1'b1;
    end else begin
      advance = 1'b1;
    end

    if (advance) begin
      ptr_nxt = (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
    end else begin
      ptr_nxt = ptr_q;
    end
    busy_nxt = load;
    gnt_nxt  = load ? win_oh : '0;
    state_en = advance | load;
  end

  // State registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      gnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (state_en) begin
      ptr_q  <= ptr_nxt;
      gnt_q  <= gnt_nxt;
      busy_q <= busy_nxt;
    end
  end

  assign slot_ptr = ptr_q;
  assign gnt      = gnt_q;
  assign busy     = busy_q;

  // R3: an idle slot issues nothing and steps the pointer by one with wrap
  a_r3_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !win_valid) |=>
      (!busy_q && ptr_q == (($past(ptr_q) == LAST_SLOT) ? '0 : $past(ptr_q) + 1'b1)));

  // R4: a winner is granted on the next edge at the same slot
  a_r4_take_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && win_valid) |=> (busy_q && gnt_q == $past(win_oh) && $stable(ptr_q)));

  // R7: a held grant and the pointer do not move without done
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xfer_done) |=> (busy_q && $stable(gnt_q) && $stable(ptr_q)));

  // R8: done on a held grant releases it and steps the pointer
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && xfer_done) |=>
      (!busy_q && gnt_q == '0 &&
       ptr_q == (($past(ptr_q) == LAST_SLOT) ? '0 : $past(ptr_q) + 1'b1)));

  // R10: grant is one-hot-or-zero and agrees with busy
  a_r10_gnt_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(gnt_q) && (busy_q == (gnt_q != '0))));

endmodule

// File: rtl/tdm_slot_arbiter.sv
// Two-region slot-table time-division arbiter.
module tdm_slot_arbiter
  import tdm_arb_pkg::*;
#(
  parameter  int N_CLIENTS = 14,
  parameter  int N_SLOTS   = 64,
  localparam int CID_W     = $clog2(N_CLIENTS + 1),
  localparam int SLOT_W    = $clog2(N_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_region,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [CID_W-1:0]     cfg_client,
  input  logic [N_CLIENTS-1:0] ext_req,
  input  logic                 ext_done,
  output logic [N_CLIENTS-1:0] ext_gnt,
  output logic                 ext_busy,
  output logic [SLOT_W-1:0]    ext_slot,
  input  logic [N_CLIENTS-1:0] int_req,
  input  logic                 int_done,
  output logic [N_CLIENTS-1:0] int_gnt,
  output logic                 int_busy,
  output logic [SLOT_W-1:0]    int_slot
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      core_rst_n <= rst_meta_q;
    end
  end

  // Region-indexed views of the ports (index 0 external, 1 internal)
  logic [REGION_COUNT-1:0][N_CLIENTS-1:0] req_a, gnt_a;
  logic [REGION_COUNT-1:0][SLOT_W-1:0]    slot_a;
  logic [REGION_COUNT-1:0]                done_a, busy_a;

  assign req_a[0]  = ext_req;
  assign req_a[1]  = int_req;
  assign done_a[0] = ext_done;
  assign done_a[1] = int_done;

  assign ext_gnt  = gnt_a[0];
  assign int_gnt  = gnt_a[1];
  assign ext_busy = busy_a[0];
  assign int_busy = busy_a[1];
  assign ext_slot = slot_a[0];
  assign int_slot = slot_a[1];

  generate
    for (genvar r = 0; r < REGION_COUNT; r++) begin : g_region
      localparam region_e RID = region_e'(r);

      logic                 tbl_we;
      logic [CID_W-1:0]     owner_id;
      logic                 win_valid;
      logic [N_CLIENTS-1:0] win_oh;

      assign tbl_we = cfg_we && (region_e'(cfg_region) == RID);

      tdm_slot_table #(
        .N_SLOTS (N_SLOTS),
        .CID_W   (CID_W),
        .SLOT_W  (SLOT_W)
      ) u_table (
        .clk    (clk),
        .rst_n  (core_rst_n),
        .wr_en  (tbl_we),
        .wr_idx (cfg_slot),
        .wr_val (cfg_client),
        .rd_idx (slot_a[r]),
        .rd_val (owner_id)
      );

      tdm_grant_picker #(
        .N_CLIENTS (N_CLIENTS),
        .CID_W     (CID_W)
      ) u_pick (
        .owner_id  (owner_id),
        .req       (req_a[r]),
        .win_valid (win_valid),
        .win_oh    (win_oh)
      );

      tdm_region_seq #(
        .N_CLIENTS (N_CLIENTS),
        .N_SLOTS   (N_SLOTS),
        .SLOT_W    (SLOT_W)
      ) u_seq (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .win_valid (win_valid),
        .win_oh    (win_oh),
        .xfer_done (done_a[r]),
        .slot_ptr  (slot_a[r]),
        .gnt       (gnt_a[r]),
        .busy      (busy_a[r])
      );
    end
  endgenerate

endmodule

// File: tb/tb_tdm_slot_arbiter.sv
module tb_tdm_slot_arbiter;

  localparam int NC = 14;
  localparam int NS = 64;
  localparam int CW = $clog2(NC + 1);
  localparam int SW = $clog2(NS);
  localparam int NV = 12;

  // {region, owner written to next slot, requests, expected grant}
  localparam logic [32:0] VECS [NV] = '{
    {1'b0, 4'd5,  14'h0021, 14'h0020},
    {1'b1, 4'd5,  14'h0003, 14'h0001},
    {1'b0, 4'd13, 14'h2100, 14'h2000},
    {1'b1, 4'd14, 14'h0300, 14'h0100},
    {1'b0, 4'd15, 14'h2000, 14'h2000},
    {1'b1, 4'd0,  14'h3FFF, 14'h0001},
    {1'b0, 4'd2,  14'h0018, 14'h0008},
    {1'b1, 4'd7,  14'h0080, 14'h0080},
    {1'b0, 4'd14, 14'h3000, 14'h1000},
    {1'b1, 4'd13, 14'h2000, 14'h2000},
    {1'b0, 4'd9,  14'h0200, 14'h0200},
    {1'b1, 4'd4,  14'h0C00, 14'h0400}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, cfg_we, cfg_region;
  logic [SW-1:0] cfg_slot;
  logic [CW-1:0] cfg_client;
  logic [NC-1:0] ext_req, int_req, ext_gnt, int_gnt;
  logic          ext_done, int_done, ext_busy, int_busy;
  logic [SW-1:0] ext_slot, int_slot;

  tdm_slot_arbiter dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_slot(cfg_slot), .cfg_client(cfg_client),
    .ext_req(ext_req), .ext_done(ext_done), .ext_gnt(ext_gnt), .ext_busy(ext_busy), .ext_slot(ext_slot),
    .int_req(int_req), .int_done(int_done), .int_gnt(int_gnt), .int_busy(int_busy), .int_slot(int_slot)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] gnt_of(input bit r);
    return r ? int_gnt : ext_gnt;
  endfunction
  function automatic logic busy_of(input bit r);
    return r ? int_busy : ext_busy;
  endfunction
  function automatic logic [SW-1:0] slot_of(input bit r);
    return r ? int_slot : ext_slot;
  endfunction

  task automatic drive_req(input bit r, input logic [NC-1:0] v);
    if (r) int_req = v; else ext_req = v;
  endtask
  task automatic drive_done(input bit r, input logic v);
    if (r) int_done = v; else ext_done = v;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] prev_e, prev_i, p, pn, other_p, hold_p;
    logic [NC-1:0] other_g, hold_g, rq, ex;
    logic [CW-1:0] own;
    bit            r;
    string         tag;

    rst_n = 1'b0; cfg_we = 1'b0; cfg_region = 1'b0; cfg_slot = '0; cfg_client = '0;
    ext_req = '0; int_req = '0; ext_done = 1'b0; int_done = 1'b0;

    // R2: reset state
    repeat (3) @(negedge clk);
    check(ext_gnt == '0 && int_gnt == '0, "R2", "grant in reset", 32'(ext_gnt | int_gnt), 0);
    check(!ext_busy && !int_busy, "R2", "busy in reset", 32'({ext_busy, int_busy}), 0);
    check(ext_slot == '0 && int_slot == '0, "R2", "slot in reset", 32'({ext_slot, int_slot}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 idle walk with wrap; R8 done while idle is ignored
    ext_done = 1'b1;
    prev_e = ext_slot;
    prev_i = int_slot;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      check(ext_slot == SW'(prev_e + 1'b1), "R3", "ext idle step", 32'(ext_slot), 32'(SW'(prev_e + 1'b1)));
      check(int_slot == SW'(prev_i + 1'b1), "R3", "int idle step", 32'(int_slot), 32'(SW'(prev_i + 1'b1)));
      check(ext_gnt == '0 && !ext_busy, "R8", "idle done gives no grant", 32'(ext_gnt), 0);
      prev_e = ext_slot;
      prev_i = int_slot;
    end
    ext_done = 1'b0;

    // R2: reset-time table is unowned, so lowest requester wins
    ext_req = 14'h0006;
    int_req = 14'h0006;
    @(negedge clk);
    check(ext_gnt == 14'h0002 && ext_busy, "R2", "ext first grant", 32'(ext_gnt), 32'h2);
    check(int_gnt == 14'h0002 && int_busy, "R2", "int first grant", 32'(int_gnt), 32'h2);

    // R7 hold with requests withdrawn; R9 write to held slot leaves grant
    ext_req = '0;
    int_req = '0;
    hold_p = ext_slot;
    cfg_we = 1'b1; cfg_region = 1'b0; cfg_slot = ext_slot; cfg_client = 4'd3;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      check(ext_gnt == 14'h0002 && ext_busy, "R7", "ext grant held", 32'(ext_gnt), 32'h2);
      check(ext_slot == hold_p, "R9", "ext slot held across write", 32'(ext_slot), 32'(hold_p));
      check(int_gnt == 14'h0002, "R7", "int grant held", 32'(int_gnt), 32'h2);
    end

    // Vector table: release current grant, program next slot, check new grant
    for (int i = 0; i < NV; i++) begin
      r   = VECS[i][32];
      own = VECS[i][31:28];
      rq  = VECS[i][27:14];
      ex  = VECS[i][13:0];
      p   = slot_of(r);
      pn  = SW'(p + 1'b1);
      other_p = slot_of(!r);
      other_g = gnt_of(!r);
      if (int'(own) >= NC) tag = "R6";
      else if (ex == (NC'(1) << own)) tag = "R4";
      else tag = "R5";

      cfg_we = 1'b1; cfg_region = r; cfg_slot = pn; cfg_client = own;
      drive_req(r, rq);
      drive_done(r, 1'b1);
      @(negedge clk);
      cfg_we = 1'b0;
      drive_done(r, 1'b0);
      check(gnt_of(r) == '0 && !busy_of(r), "R8", $sformatf("vector %0d release", i), 32'(gnt_of(r)), 0);
      check(slot_of(r) == pn, "R8", $sformatf("vector %0d step", i), 32'(slot_of(r)), 32'(pn));
      @(negedge clk);
      check(gnt_of(r) == ex && busy_of(r), tag, $sformatf("vector %0d grant", i), 32'(gnt_of(r)), 32'(ex));
      check(slot_of(!r) == other_p && gnt_of(!r) == other_g, "R1",
            $sformatf("vector %0d other region untouched", i), 32'(slot_of(!r)), 32'(other_p));
    end

    // R1: an internal-region write must not reach the external table
    p  = ext_slot;
    pn = SW'(p + 1'b1);
    cfg_we = 1'b1; cfg_region = 1'b0; cfg_slot = pn; cfg_client = 4'd6;
    @(negedge clk);
    cfg_region = 1'b1; cfg_slot = pn; cfg_client = 4'd11;
    ext_req = 14'h0802;
    ext_done = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    ext_done = 1'b0;
    @(negedge clk);
    check(ext_gnt == 14'h0002, "R1", "region write isolation", 32'(ext_gnt), 32'h2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule